// File: doc/BRIEF.md
# Three-Band Temperature Alarm Light Controller

This block turns 8-bit temperature readings from a parallel converter port into a two-LED traffic light and a single alarm line. A converter places a reading on the data pins and raises its conversion-done line, and the block keeps that reading in a holding register. A slow periodic measurement strobe then moves the held reading into the classifier. Each reading falls into one of three bands. A cool reading lights green. A warm reading lights red and green together, which shows as yellow. A hot reading lights red alone and sets the alarm.

The alarm latches. Later cool or warm readings change the LEDs but leave the alarm set. Only a long press of a push button clears it. The button is synchronized and then timed. When it has been held for a set number of cycles, an internal clear signal goes active. That signal darkens both LEDs and the alarm and keeps them dark for as long as the button stays down. Every LED and alarm output is registered, and each one follows a new reading after a fixed latency.

Top module: `tl_alarm_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `led_red`, `led_green` and `alarm` to 0 after that edge, and the band state returns to idle. Idle means all outputs stay 0 until a new reading is taken.
- R2: A reading below `LOW_MIN` (default 100) gives `led_green`=1, `led_red`=0.
- R3: A reading from `LOW_MIN` to `HIGH_MAX` inclusive (default 100 to 168) gives `led_red`=1 and `led_green`=1.
- R4: A reading above `HIGH_MAX` (default 168) gives `led_red`=1, `led_green`=0 and sets `alarm`=1.
- R5: Let clock edge k be the first edge at which `meas_strobe` is sampled high. The outputs keep their earlier values through edge k+OUT_STAGES, and they show the new reading's band after edge k+OUT_STAGES+1. With the default OUT_STAGES=4, this is edge k+5.
- R6: `adc_data` is copied into the holding register at every edge where `adc_eoc` is high. While `adc_eoc` is low, changes on `adc_data` do not affect the value that the strobe takes.
- R7: A strobe takes exactly one reading per high period. While `meas_strobe` stays high, it takes no further reading, even if the holding register changes. A new reading needs the strobe to go low and then high again.
- R8: Once `alarm` is 1, it stays 1 when later readings fall into the low or middle band. The LEDs follow each new band.
- R9: `btn_hold` passes through a two-flop synchronizer. After the synchronized level has been high for HOLD_CYCLES consecutive edges, the hold-clear goes active. All outputs are then 0 after the next edge. With an asynchronous press that starts just before edge 1, outputs are still unchanged after edge HOLD_CYCLES+2 and are 0 after edge HOLD_CYCLES+3. A press shorter than HOLD_CYCLES synchronized cycles changes nothing, and releasing the button restarts the count.
- R10: While the hold-clear is active, `led_red`, `led_green` and `alarm` stay 0, and readings taken by the strobe are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_data | input | DATA_W (8) | Parallel converter reading |
| adc_eoc | input | 1 | Conversion done; loads the holding register |
| meas_strobe | input | 1 | Periodic measurement strobe; its rising level takes one reading |
| btn_hold | input | 1 | Raw push-button level (asynchronous) |
| led_red | output | 1 | Red LED drive |
| led_green | output | 1 | Green LED drive |
| alarm | output | 1 | Latched over-temperature alarm |

## Verification
A band register holding the wrong value appears as a wrong LED pair exactly OUT_STAGES+1 edges after the strobe. A wrong latch appears as an alarm that is missing or that drops early on the next cool reading. Both are visible at the ports within one reading period. A hold counter that is off by one moves the darkening edge by one cycle, so the bench samples on both sides of the expected edge. A capture flag that does not stick shows up as an extra band change while the strobe is held high.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [1:0] {
    BAND_IDLE = 2'd0,
    BAND_COOL = 2'd1,
    BAND_WARM = 2'd2,
    BAND_HOT  = 2'd3
  } band_e;

  typedef struct packed {
    logic red;
    logic green;
    logic alarm;
  } lights_t;

  localparam lights_t LIGHTS_DARK = '{red: 1'b0, green: 1'b0, alarm: 1'b0};

endpackage

// File: rtl/tl_hold_timer.sv
module tl_hold_timer #(
  parameter int HOLD_CYCLES = 12_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic hold_clr
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   btn_s;

  // two-flop (or deeper) synchronizer for the asynchronous button
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw};
  end

  assign btn_s = sync_q[SYNC_STAGES-1];

  // count consecutive held cycles, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst || !btn_s)          cnt_q <= '0;
    else if (cnt_q != HOLD_LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign hold_clr = (cnt_q == HOLD_LIM);
endmodule

// File: rtl/tl_sample_port.sv
module tl_sample_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_eoc,
  input  logic              meas_strobe,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_new
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] smp_q;
  logic              taken_q;
  logic              new_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      smp_q   <= '0;
      taken_q <= 1'b0;
      new_q   <= 1'b0;
    end else begin
      if (adc_eoc) hold_q <= adc_data;
      new_q <= 1'b0;
      if (meas_strobe && !taken_q) begin
        smp_q   <= hold_q;
        taken_q <= 1'b1;
        new_q   <= 1'b1;
      end else if (!meas_strobe) begin
        taken_q <= 1'b0;
      end
    end
  end

  assign smp_data = smp_q;
  assign smp_new  = new_q;
endmodule

// File: rtl/tl_band_eval.sv
module tl_band_eval
  import tl_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-1:0] LOW_MIN  = 8'd100,
  parameter logic [DATA_W-1:0] HIGH_MAX = 8'd168
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_clr,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_new,
  output lights_t           lights
);
  band_e band_q;
  band_e band_d;
  logic  alarm_q;

  always_comb begin
    if (smp_data < LOW_MIN)        band_d = BAND_COOL;
    else if (smp_data <= HIGH_MAX) band_d = BAND_WARM;
    else                           band_d = BAND_HOT;
  end

  always_ff @(posedge clk) begin
    if (rst || hold_clr) begin
      band_q  <= BAND_IDLE;
      alarm_q <= 1'b0;
    end else if (smp_new) begin
      band_q <= band_d;
      if (band_d == BAND_HOT) alarm_q <= 1'b1;
    end
  end

  always_comb begin
    lights       = LIGHTS_DARK;
    lights.alarm = alarm_q;
    unique case (band_q)
      BAND_COOL: lights.green = 1'b1;
      BAND_WARM: begin lights.red = 1'b1; lights.green = 1'b1; end
      BAND_HOT:  lights.red = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/tl_out_pipe.sv
module tl_out_pipe
  import tl_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    flush,
  input  lights_t din,
  output lights_t dout
);
  lights_t stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || flush) stg_q[i] <= LIGHTS_DARK;
      else if (i == 0)  stg_q[i] <= din;
      else              stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/tl_alarm_ctrl.sv
module tl_alarm_ctrl
  import tl_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-1:0] LOW_MIN     = 8'd100,
  parameter logic [DATA_W-1:0] HIGH_MAX    = 8'd168,
  parameter int                HOLD_CYCLES = 12_000_000,
  parameter int                OUT_STAGES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_eoc,
  input  logic              meas_strobe,
  input  logic              btn_hold,
  output logic              led_red,
  output logic              led_green,
  output logic              alarm
);
  logic              hold_clr;
  logic [DATA_W-1:0] smp_data;
  logic              smp_new;
  lights_t           band_lights;
  lights_t           out_lights;

  tl_hold_timer #(
    .HOLD_CYCLES(HOLD_CYCLES),
    .SYNC_STAGES(2)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .btn_raw (btn_hold),
    .hold_clr(hold_clr)
  );

  tl_sample_port #(
    .DATA_W(DATA_W)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .adc_data   (adc_data),
    .adc_eoc    (adc_eoc),
    .meas_strobe(meas_strobe),
    .smp_data   (smp_data),
    .smp_new    (smp_new)
  );

  tl_band_eval #(
    .DATA_W  (DATA_W),
    .LOW_MIN (LOW_MIN),
    .HIGH_MAX(HIGH_MAX)
  ) u_band (
    .clk     (clk),
    .rst     (rst),
    .hold_clr(hold_clr),
    .smp_data(smp_data),
    .smp_new (smp_new),
    .lights  (band_lights)
  );

  tl_out_pipe #(
    .STAGES(OUT_STAGES)
  ) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .flush(hold_clr),
    .din  (band_lights),
    .dout (out_lights)
  );

  assign led_red   = out_lights.red;
  assign led_green = out_lights.green;
  assign alarm     = out_lights.alarm;
endmodule

// File: rtl/tl_alarm_ctrl_chk.sv
module tl_alarm_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic hold_clr,
  input logic led_red,
  input logic led_green,
  input logic alarm
);
  // R1
  reset_dark_chk: assert property (@(posedge clk)
    rst |=> (!led_red && !led_green && !alarm));

  // R10
  hold_dark_chk: assert property (@(posedge clk) disable iff (rst)
    hold_clr |=> (!led_red && !led_green && !alarm));

  // R4
  alarm_rise_hot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> (led_red && !led_green));

  // R8
  alarm_lit_chk: assert property (@(posedge clk) disable iff (rst)
    alarm |-> (led_red || led_green));

  // R9
  alarm_fall_dark_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm) |-> (!led_red && !led_green));
endmodule

bind tl_alarm_ctrl tl_alarm_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .hold_clr (hold_clr),
  .led_red  (led_red),
  .led_green(led_green),
  .alarm    (alarm)
);

// File: tb/tl_alarm_ctrl_bench.sv
module tl_alarm_ctrl_bench;
  localparam int HOLD = 8;
  localparam int STG  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] adc_data = '0;
  logic       adc_eoc = 1'b0;
  logic       meas_strobe = 1'b0;
  logic       btn_hold = 1'b0;
  logic       led_red, led_green, alarm;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tl_alarm_ctrl #(
    .HOLD_CYCLES(HOLD),
    .OUT_STAGES (STG)
  ) u_tl_alarm_ctrl (
    .clk        (clk),
    .rst        (rst),
    .adc_data   (adc_data),
    .adc_eoc    (adc_eoc),
    .meas_strobe(meas_strobe),
    .btn_hold   (btn_hold),
    .led_red    (led_red),
    .led_green  (led_green),
    .alarm      (alarm)
  );

  // {data, red, green, alarm}
  localparam logic [10:0] VEC [8] = '{
    {8'd0,   3'b010}, {8'd99,  3'b010}, {8'd100, 3'b110}, {8'd168, 3'b110},
    {8'd169, 3'b101}, {8'd120, 3'b111}, {8'd50,  3'b011}, {8'd255, 3'b101}
  };

  task automatic check(input string req, input logic [2:0] exp);
    total++;
    if ({led_red, led_green, alarm} !== exp) begin
      bad++;
      $display("FAIL %s: got r/g/a=%b expected %b at %0t", req,
               {led_red, led_green, alarm}, exp, $time);
    end
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk); adc_data = d; adc_eoc = 1'b1;
    @(negedge clk); adc_eoc = 1'b0;
  endtask

  // strobe first sampled at edge k; check after k+4 (old) and k+5 (new)
  task automatic strobe(input string req, input logic [2:0] old_v, input logic [2:0] new_v);
    meas_strobe = 1'b1;
    @(negedge clk); @(negedge clk);
    meas_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check({req, " R5 before latency"}, old_v);
    @(negedge clk);
    check(req, new_v);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [2:0] prev;
    repeat (3) @(negedge clk);
    check("R1 reset state", 3'b000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", 3'b000);

    // R2 R3 R4 R8 band table
    prev = 3'b000;
    for (int i = 0; i < 8; i++) begin
      load(VEC[i][10:3]);
      strobe("R2/R3/R4/R8 table", prev, VEC[i][2:0]);
      prev = VEC[i][2:0];
    end

    // R9 short press does nothing
    @(negedge clk); btn_hold = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    btn_hold = 1'b0;
    repeat (HOLD + 4) @(negedge clk);
    check("R9 short press ignored", 3'b101);

    // R9 long press: unchanged after edge HOLD+2, dark after HOLD+3
    btn_hold = 1'b1;
    repeat (HOLD + 2) @(negedge clk);
    check("R9 before hold limit", 3'b101);
    @(negedge clk);
    check("R9 hold clears", 3'b000);

    // R10 strobe during hold discarded
    load(8'd255);
    strobe("R10 strobe while held", 3'b000, 3'b000);
    repeat (4) @(negedge clk);
    check("R10 stays dark", 3'b000);
    btn_hold = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 idle after release", 3'b000);

    // R6 eoc low keeps held value
    load(8'd200);
    @(negedge clk); adc_data = 8'd10;
    strobe("R6 held value used", 3'b000, 3'b101);

    // clear alarm with rst mid-run (R1)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset mid-run", 3'b000);

    // R7 one reading per strobe high period
    load(8'd30);
    meas_strobe = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 first reading", 3'b010);
    adc_data = 8'd150; adc_eoc = 1'b1;
    @(negedge clk); adc_eoc = 1'b0;
    repeat (8) @(negedge clk);
    check("R7 no second capture while high", 3'b010);
    meas_strobe = 1'b0;
    @(negedge clk);
    strobe("R7 new high period takes reading", 3'b010, 3'b110);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule